// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Data Cache

This block is a data cache that sits between a processor's load/store port and a lower-level memory. The memory port moves whole blocks. Each physical byte address is split into three fields: a block offset, a set index and a tag. Both ways of the indexed set are compared in the same cycle. On a hit, the request is accepted at once, and load data comes back one cycle later. On a miss, the cache chooses a victim: an invalid way if one exists, otherwise the least recently used way. It then refills the block and replays the request, which now hits.

Stores follow a write-back, write-allocate policy. A store miss first brings the block in. The store bytes are merged only after the tag check confirms a hit in a specific way. A modified block that is evicted moves into a one-entry victim buffer. The buffer drains that block to memory on its own, while the refill read goes ahead without waiting. A miss whose block is still in the buffer takes its data from there and issues no memory read. A second dirty eviction waits until the buffer is empty.

Top module: `dcache_2way`

## Requirements
- R1: After reset every block is invalid, so the first access to any address is not accepted in the cycle it is presented. `rsp_valid`, `mem_rd_req` and `mem_wr_valid` are low.
- R2: When the tag of a valid block in either way matches, `req_ready` is high in the cycle the request is presented. For a load, `rsp_valid` pulses one cycle after acceptance, and `rsp_rdata` then holds the 32-bit word chosen by address bits [5:2].
- R3: The address bits are used as follows: [5:0] is the byte offset, [14:6] selects one of 512 sets, and [43:15] is the 29-bit tag. Equal tags with different indices are different blocks.
- R4: On a miss, `req_ready` stays low while the cache holds `mem_rd_req` high with `mem_rd_addr` set to address bits [43:6]. The request and address stay until `mem_rd_rvalid`. After the fill, the request completes as a hit with memory's data.
- R5: A store hit writes byte i of `req_wdata` (bits 8i+7:8i) only where `req_be[i]` is 1. The other bytes of the word keep their old values.
- R6: A store miss fetches the block first and then merges the store bytes into it (write-allocate). No data array changes before the tag check confirms a hit.
- R7: The victim is an invalid way if one exists (way 0 first). Otherwise it is the least recently used way of the set. Recency is updated on every hit and every fill.
- R8: A clean victim is overwritten without any memory write.
- R9: A dirty victim goes into the victim buffer. The buffer holds `mem_wr_valid`, `mem_wr_addr` (the block address) and `mem_wr_data` until `mem_wr_ready`, and the data it writes includes the stores. The refill read is issued without waiting for that write.
- R10: A miss whose block address equals the one held in the victim buffer is filled from the buffer, with no memory read.
- R11: If a dirty eviction is needed while the buffer is still full, the miss stalls: no memory read is issued and no request is accepted until the buffer has drained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor request present, held until accepted |
| req_ready | output | 1 | Request accepted this cycle (hit) |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 44 | Physical byte address |
| req_wdata | input | 32 | Store data |
| req_be | input | 4 | Store byte enables |
| rsp_valid | output | 1 | Load data valid (one cycle after acceptance) |
| rsp_rdata | output | 32 | Load data |
| mem_rd_req | output | 1 | Block read request, held until data returns |
| mem_rd_addr | output | 38 | Block address to read |
| mem_rd_rvalid | input | 1 | Read data returned this cycle |
| mem_rd_data | input | 512 | Returned block |
| mem_wr_valid | output | 1 | Victim buffer holds a block to write |
| mem_wr_ready | input | 1 | Memory takes the block this cycle |
| mem_wr_addr | output | 38 | Block address being written back |
| mem_wr_data | output | 512 | Block being written back |

## Verification
The bench runs a single set through a sequence of hits, cold misses and evictions. This sequence exposes a recency bit that is set the wrong way or never updated: the wrong block would miss on a later access. It also checks partial-byte stores and store misses. A cache that merged bytes before the fill, or that ignored the byte mask, would return corrupted words.

The write-back path is tested with the memory write port held off, in two cases. First, a miss on a block still in the victim buffer must read nothing from memory. Second, a second dirty eviction must wait without issuing a read. A design that overwrote a full buffer would lose modified data, and the later read-back from memory would show this.

// File: rtl/dcache_pkg.sv
`timescale 1ns/1ps
package dcache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MISS = 2'd1,
    ST_FILL = 2'd2
  } dc_state_t;
endpackage

// File: rtl/dcache_tag_way.sv
`timescale 1ns/1ps
// One way of tag, valid and dirty state, with its own comparator.
module dcache_tag_way #(
  parameter int TAG_W   = 29,
  parameter int SETS    = 512,
  parameter int INDEX_W = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INDEX_W-1:0] rd_idx,
  input  logic [TAG_W-1:0]   cmp_tag,
  output logic               hit,
  output logic               line_valid,
  output logic               line_dirty,
  output logic [TAG_W-1:0]   line_tag,
  input  logic               fill_en,
  input  logic [INDEX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0]   fill_tag,
  input  logic               dirty_en,
  input  logic [INDEX_W-1:0] dirty_idx
);
  logic [TAG_W-1:0] tag_mem [SETS];
  logic [SETS-1:0]  valid_q;
  logic [SETS-1:0]  dirty_q;

  always_ff @(posedge clk) begin
    if (fill_en) tag_mem[fill_idx] <= fill_tag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      if (fill_en) begin
        valid_q[fill_idx] <= 1'b1;
        dirty_q[fill_idx] <= 1'b0;
      end
      if (dirty_en) dirty_q[dirty_idx] <= 1'b1;
    end
  end

  assign line_tag   = tag_mem[rd_idx];
  assign line_valid = valid_q[rd_idx];
  assign line_dirty = dirty_q[rd_idx];
  assign hit        = line_valid && (line_tag == cmp_tag);

  // A fill and a store never touch the same way in the same cycle.
  a_r6_fill_store_apart: assert property (@(posedge clk) disable iff (rst)
    !(fill_en && dirty_en));
endmodule

// File: rtl/dcache_data_way.sv
`timescale 1ns/1ps
// One way of block data: one write port, one read port.
module dcache_data_way #(
  parameter int LINE_W  = 512,
  parameter int SETS    = 512,
  parameter int INDEX_W = 9
) (
  input  logic               clk,
  input  logic [INDEX_W-1:0] rd_idx,
  output logic [LINE_W-1:0]  rd_line,
  input  logic               wr_en,
  input  logic [INDEX_W-1:0] wr_idx,
  input  logic [LINE_W-1:0]  wr_line
);
  logic [LINE_W-1:0] line_mem [SETS];

  always_ff @(posedge clk) begin
    if (wr_en) line_mem[wr_idx] <= wr_line;
  end

  assign rd_line = line_mem[rd_idx];
endmodule

// File: rtl/dcache_victim_buf.sv
`timescale 1ns/1ps
// One-entry holding register for an evicted modified block.
module dcache_victim_buf #(
  parameter int BLK_W  = 38,
  parameter int LINE_W = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [BLK_W-1:0]  load_blk,
  input  logic [LINE_W-1:0] load_line,
  input  logic [BLK_W-1:0]  match_blk,
  output logic              match,
  output logic              out_valid,
  output logic [BLK_W-1:0]  out_blk,
  output logic [LINE_W-1:0] out_line,
  input  logic              drain_ready
);
  logic              held_q;
  logic [BLK_W-1:0]  blk_q;
  logic [LINE_W-1:0] line_q;

  always_ff @(posedge clk) begin
    if (rst) held_q <= 1'b0;
    else if (load_en) held_q <= 1'b1;
    else if (held_q && drain_ready) held_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      blk_q  <= load_blk;
      line_q <= load_line;
    end
  end

  assign out_valid = held_q;
  assign out_blk   = blk_q;
  assign out_line  = line_q;
  assign match     = held_q && (blk_q == match_blk);

  a_r11_load_only_empty: assert property (@(posedge clk) disable iff (rst)
    load_en |-> !held_q);
  a_r9_hold_until_taken: assert property (@(posedge clk) disable iff (rst)
    (held_q && !drain_ready) |=> (held_q && $stable(blk_q)));
endmodule

// File: rtl/dcache_2way.sv
`timescale 1ns/1ps
module dcache_2way import dcache_pkg::*; #(
  parameter int ADDR_W   = 44,
  parameter int OFFSET_W = 6,
  parameter int SETS     = 512,
  parameter int WORD_W   = 32,
  localparam int INDEX_W = $clog2(SETS),
  localparam int TAG_W   = ADDR_W - OFFSET_W - INDEX_W,
  localparam int BLK_W   = ADDR_W - OFFSET_W,
  localparam int LINE_W  = 8 * (2 ** OFFSET_W),
  localparam int BE_W    = WORD_W / 8,
  localparam int WORDS   = LINE_W / WORD_W,
  localparam int WSEL_W  = $clog2(WORDS),
  localparam int WOFF_W  = $clog2(BE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  input  logic [BE_W-1:0]   req_be,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              mem_rd_req,
  output logic [BLK_W-1:0]  mem_rd_addr,
  input  logic              mem_rd_rvalid,
  input  logic [LINE_W-1:0] mem_rd_data,
  output logic              mem_wr_valid,
  input  logic              mem_wr_ready,
  output logic [BLK_W-1:0]  mem_wr_addr,
  output logic [LINE_W-1:0] mem_wr_data
);
  localparam int WAYS = 2;

  dc_state_t          state_q;
  logic [INDEX_W-1:0] req_idx, rd_idx, wr_idx, miss_idx_q;
  logic [TAG_W-1:0]   req_tag, miss_tag_q;
  logic [WSEL_W-1:0]  req_wsel;
  logic [BLK_W-1:0]   miss_blk;
  logic               miss_way_q;
  logic [WAYS-1:0]    hit, way_valid, way_dirty;
  logic [WAYS-1:0]    tag_fill_en, tag_dirty_en, data_wr_en;
  logic [TAG_W-1:0]   way_tag  [WAYS];
  logic [LINE_W-1:0]  way_line [WAYS];
  logic [LINE_W-1:0]  hit_line, merged_line, fill_line, wr_line;
  logic               any_hit, hit_way, accept, store_hit;
  logic               fill_go, vb_load, vb_match, vict_way, vict_dirty;
  logic [SETS-1:0]    lru_q;   // per set: the way to evict next
  logic [LINE_W-1:0]  vb_line;

  // Address fields
  assign req_idx  = req_addr[OFFSET_W +: INDEX_W];
  assign req_tag  = req_addr[ADDR_W-1 -: TAG_W];
  assign req_wsel = req_addr[WOFF_W +: WSEL_W];
  assign miss_blk = {miss_tag_q, miss_idx_q};
  assign rd_idx   = (state_q == ST_IDLE) ? req_idx : miss_idx_q;

  // Hit detection and acceptance
  assign any_hit   = |hit;
  assign hit_way   = hit[1];
  assign accept    = (state_q == ST_IDLE) && req_valid && any_hit;
  assign req_ready = accept;
  assign store_hit = accept && req_write;
  assign hit_line  = way_line[hit_way];

  // Byte-masked merge of a store into the hit block
  always_comb begin
    merged_line = hit_line;
    for (int b = 0; b < BE_W; b++) begin
      if (req_be[b])
        merged_line[int'(req_wsel) * WORD_W + 8 * b +: 8] = req_wdata[8 * b +: 8];
    end
  end

  // Victim choice: invalid way first, else the recency bit
  always_comb begin
    if (!way_valid[0])      vict_way = 1'b0;
    else if (!way_valid[1]) vict_way = 1'b1;
    else                    vict_way = lru_q[rd_idx];
  end

  assign vict_dirty = way_valid[miss_way_q] && way_dirty[miss_way_q];

  // Miss sequence controls
  always_comb begin
    fill_go   = 1'b0;
    vb_load   = 1'b0;
    fill_line = mem_rd_data;
    case (state_q)
      ST_MISS: begin
        if (!vict_dirty && vb_match) begin
          fill_go   = 1'b1;
          fill_line = vb_line;
        end else if (vict_dirty && !mem_wr_valid) begin
          vb_load = 1'b1;
        end
      end
      ST_FILL: fill_go = mem_rd_rvalid;
      default: ;
    endcase
  end

  assign wr_line = fill_go ? fill_line : merged_line;
  assign wr_idx  = fill_go ? miss_idx_q : req_idx;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign tag_fill_en[w]  = fill_go && (miss_way_q == 1'(w));
    assign tag_dirty_en[w] = store_hit && hit[w];
    assign data_wr_en[w]   = tag_fill_en[w] || tag_dirty_en[w];

    dcache_tag_way #(.TAG_W(TAG_W), .SETS(SETS), .INDEX_W(INDEX_W)) u_tag (
      .clk        (clk),
      .rst        (rst),
      .rd_idx     (rd_idx),
      .cmp_tag    (req_tag),
      .hit        (hit[w]),
      .line_valid (way_valid[w]),
      .line_dirty (way_dirty[w]),
      .line_tag   (way_tag[w]),
      .fill_en    (tag_fill_en[w]),
      .fill_idx   (miss_idx_q),
      .fill_tag   (miss_tag_q),
      .dirty_en   (tag_dirty_en[w]),
      .dirty_idx  (req_idx)
    );

    dcache_data_way #(.LINE_W(LINE_W), .SETS(SETS), .INDEX_W(INDEX_W)) u_data (
      .clk     (clk),
      .rd_idx  (rd_idx),
      .rd_line (way_line[w]),
      .wr_en   (data_wr_en[w]),
      .wr_idx  (wr_idx),
      .wr_line (wr_line)
    );
  end

  dcache_victim_buf #(.BLK_W(BLK_W), .LINE_W(LINE_W)) u_vbuf (
    .clk         (clk),
    .rst         (rst),
    .load_en     (vb_load),
    .load_blk    ({way_tag[miss_way_q], miss_idx_q}),
    .load_line   (way_line[miss_way_q]),
    .match_blk   (miss_blk),
    .match       (vb_match),
    .out_valid   (mem_wr_valid),
    .out_blk     (mem_wr_addr),
    .out_line    (vb_line),
    .drain_ready (mem_wr_ready)
  );
  assign mem_wr_data = vb_line;

  // State, recency and registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      lru_q       <= '0;
      miss_idx_q  <= '0;
      miss_tag_q  <= '0;
      miss_way_q  <= 1'b0;
      mem_rd_req  <= 1'b0;
      mem_rd_addr <= '0;
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
    end else begin
      rsp_valid <= accept && !req_write;
      if (accept && !req_write)
        rsp_rdata <= hit_line[int'(req_wsel) * WORD_W +: WORD_W];
      if (accept)  lru_q[req_idx]    <= ~hit_way;
      if (fill_go) lru_q[miss_idx_q] <= ~miss_way_q;

      case (state_q)
        ST_IDLE: begin
          if (req_valid && !any_hit) begin
            miss_idx_q <= req_idx;
            miss_tag_q <= req_tag;
            miss_way_q <= vict_way;
            state_q    <= ST_MISS;
          end
        end
        ST_MISS: begin
          if (vict_dirty) begin
            if (!mem_wr_valid) begin
              mem_rd_req  <= 1'b1;
              mem_rd_addr <= miss_blk;
              state_q     <= ST_FILL;
            end
          end else if (vb_match) begin
            state_q <= ST_IDLE;
          end else begin
            mem_rd_req  <= 1'b1;
            mem_rd_addr <= miss_blk;
            state_q     <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (mem_rd_rvalid) begin
            mem_rd_req <= 1'b0;
            state_q    <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Checks
  a_r7_one_way_hits: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit));
  a_r2_rsp_after_load: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid && req_ready && !req_write));
  a_r4_read_held: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_req && !mem_rd_rvalid) |=> (mem_rd_req && $stable(mem_rd_addr)));
  a_r6_no_write_on_miss: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && req_valid && req_write && !any_hit) |-> !(|data_wr_en));
  a_r10_buffer_fill_no_read: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_MISS && fill_go) |-> !mem_rd_req);
  a_r11_stall_no_read: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_MISS && vict_dirty && mem_wr_valid) |=> !mem_rd_req);
endmodule

// File: tb/dcache_2way_bench.sv
`timescale 1ns/1ps
module dcache_2way_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0, req_write = 1'b0;
  logic [43:0]  req_addr = '0;
  logic [31:0]  req_wdata = '0;
  logic [3:0]   req_be = '0;
  logic         req_ready, rsp_valid;
  logic [31:0]  rsp_rdata;
  logic         mem_rd_req, mem_rd_rvalid = 1'b0;
  logic [37:0]  mem_rd_addr, mem_wr_addr;
  logic [511:0] mem_rd_data = '0, mem_wr_data;
  logic         mem_wr_valid, mem_wr_ready = 1'b0;

  int errors = 0, checks = 0, rd_count = 0, wr_count = 0;
  bit wr_ready_en = 1'b1, done = 1'b0;

  logic [511:0] mem_model [logic [37:0]];
  logic [31:0]  shadow    [logic [41:0]];

  always #2.5 clk = ~clk;

  dcache_2way u_dcache_2way (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_rvalid(mem_rd_rvalid), .mem_rd_data(mem_rd_data),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data));

  function automatic logic [31:0] init_word(input logic [43:0] a);
    return {a[31:2], 2'b00} ^ 32'h5A5A_0000;
  endfunction

  function automatic logic [511:0] get_line(input logic [37:0] blk);
    logic [511:0] l;
    if (mem_model.exists(blk)) return mem_model[blk];
    for (int w = 0; w < 16; w++) l[w*32 +: 32] = init_word({blk, 4'(w), 2'b00});
    return l;
  endfunction

  function automatic logic [31:0] exp_word(input logic [43:0] a);
    if (shadow.exists(a[43:2])) return shadow[a[43:2]];
    return init_word(a);
  endfunction

  function automatic logic [43:0] mk(input int tag, input int idx, input int off);
    return {29'(tag), 9'(idx), 6'(off)};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Lower-level memory: block reads after a fixed latency
  initial begin
    forever begin
      @(negedge clk);
      if (mem_rd_req && !rst) begin
        rd_count++;
        repeat (3) @(negedge clk);
        mem_rd_data   = get_line(mem_rd_addr);
        mem_rd_rvalid = 1'b1;
        @(negedge clk);
        mem_rd_rvalid = 1'b0;
      end
    end
  end

  // Lower-level memory: block writes, taken when enabled
  initial begin
    forever begin
      @(negedge clk);
      mem_wr_ready = wr_ready_en;
      #1;
      if (mem_wr_valid && mem_wr_ready && !rst) begin
        mem_model[mem_wr_addr] = mem_wr_data;
        wr_count++;
      end
    end
  end

  // One processor access; first = accepted in the cycle presented
  task automatic access(input bit wr, input logic [43:0] a, input logic [31:0] d,
                        input logic [3:0] be, output bit first, output logic [31:0] rd);
    int waits = 0;
    logic [31:0] old;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    #1;
    while (!req_ready && waits < 400) begin
      @(negedge clk); #1; waits++;
    end
    first = (waits == 0);
    if (waits >= 400) check(1'b0, "R4 request never accepted", 64'(waits), 64'd0);
    @(negedge clk);
    req_valid = 1'b0;
    rd = rsp_rdata;
    if (!wr) check(rsp_valid === 1'b1, "R2 rsp_valid after load", 64'(rsp_valid), 64'd1);
    else begin
      old = exp_word(a);
      for (int b = 0; b < 4; b++) if (be[b]) old[8*b +: 8] = d[8*b +: 8];
      shadow[a[43:2]] = old;
    end
  endtask

  // Table: {wr, tag[7:0], idx[8:0], off[5:0], be[3:0], wdata[31:0], expect_hit}
  localparam int NV = 19;
  localparam logic [60:0] VEC [NV] = '{
    {1'b0, 8'd1, 9'd5,  6'd0,  4'h0, 32'h0,         1'b0},
    {1'b0, 8'd1, 9'd5,  6'd4,  4'h0, 32'h0,         1'b1},
    {1'b1, 8'd1, 9'd5,  6'd8,  4'hF, 32'h1111_2222, 1'b1},
    {1'b0, 8'd1, 9'd5,  6'd8,  4'h0, 32'h0,         1'b1},
    {1'b0, 8'd2, 9'd5,  6'd0,  4'h0, 32'h0,         1'b0},
    {1'b0, 8'd1, 9'd5,  6'd0,  4'h0, 32'h0,         1'b1},
    {1'b0, 8'd3, 9'd5,  6'd0,  4'h0, 32'h0,         1'b0},
    {1'b0, 8'd1, 9'd5,  6'd8,  4'h0, 32'h0,         1'b1},
    {1'b0, 8'd2, 9'd5,  6'd0,  4'h0, 32'h0,         1'b0},
    {1'b0, 8'd4, 9'd5,  6'd0,  4'h0, 32'h0,         1'b0},
    {1'b0, 8'd1, 9'd5,  6'd8,  4'h0, 32'h0,         1'b0},
    {1'b0, 8'd4, 9'd5,  6'd0,  4'h0, 32'h0,         1'b1},
    {1'b1, 8'd1, 9'd5,  6'd60, 4'h5, 32'hAABB_CCDD, 1'b1},
    {1'b0, 8'd1, 9'd5,  6'd60, 4'h0, 32'h0,         1'b1},
    {1'b0, 8'd1, 9'd6,  6'd0,  4'h0, 32'h0,         1'b0},
    {1'b0, 8'd1, 9'd5,  6'd60, 4'h0, 32'h0,         1'b1},
    {1'b1, 8'd5, 9'd5,  6'd12, 4'h8, 32'h9900_0000, 1'b0},
    {1'b0, 8'd5, 9'd5,  6'd12, 4'h0, 32'h0,         1'b1},
    {1'b0, 8'd1, 9'd5,  6'd60, 4'h0, 32'h0,         1'b1}
  };

  initial begin
    bit first;
    logic [31:0] rd;
    logic [43:0] a;
    int rc0, wc0;
    logic [511:0] wb;
    bit stall_done;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle outputs after reset
    check(rsp_valid === 1'b0, "R1 rsp_valid low", 64'(rsp_valid), 64'd0);
    check(mem_rd_req === 1'b0, "R1 mem_rd_req low", 64'(mem_rd_req), 64'd0);
    check(mem_wr_valid === 1'b0, "R1 mem_wr_valid low", 64'(mem_wr_valid), 64'd0);

    // R1/R2/R3/R4/R5/R6/R7 through the vector table
    for (int i = 0; i < NV; i++) begin
      a = mk(int'(VEC[i][59:52]), int'(VEC[i][51:43]), int'(VEC[i][42:37]));
      access(VEC[i][60], a, VEC[i][32:1], VEC[i][36:33], first, rd);
      check(first == VEC[i][0], $sformatf("R7 hit/miss pattern, vector %0d", i),
            64'(first), 64'(VEC[i][0]));
      if (!VEC[i][60])
        check(rd === exp_word(a), $sformatf("R5 load data, vector %0d", i), 64'(rd), 64'(exp_word(a)));
    end

    // R8: clean evictions write nothing
    repeat (8) @(negedge clk);
    wc0 = wr_count;
    access(0, mk(1, 20, 0), 0, 0, first, rd);
    access(0, mk(2, 20, 0), 0, 0, first, rd);
    access(0, mk(3, 20, 0), 0, 0, first, rd);
    check(first == 1'b0, "R8 third block misses", 64'(first), 64'd0);
    repeat (4) @(negedge clk);
    check(wr_count == wc0, "R8 no write-back for clean victim", 64'(wr_count), 64'(wc0));

    // R9/R10: dirty eviction with the write port held off
    wr_ready_en = 1'b0;
    access(1, mk(1, 30, 0), 32'hCAFE_0001, 4'hF, first, rd);
    check(first == 1'b0, "R6 store miss allocates", 64'(first), 64'd0);
    access(0, mk(2, 30, 0), 0, 0, first, rd);
    rc0 = rd_count;
    access(0, mk(3, 30, 0), 0, 0, first, rd);
    check(rd_count == rc0 + 1, "R9 refill read not held by write-back", 64'(rd_count), 64'(rc0 + 1));
    check(mem_wr_valid === 1'b1, "R9 victim waiting to drain", 64'(mem_wr_valid), 64'd1);
    check(mem_wr_addr === {29'd1, 9'd30}, "R9 victim block address", 64'(mem_wr_addr), 64'({29'd1, 9'd30}));
    check(mem_wr_data[31:0] === 32'hCAFE_0001, "R9 victim holds store", 64'(mem_wr_data[31:0]), 64'hCAFE0001);
    rc0 = rd_count;
    access(0, mk(1, 30, 0), 0, 0, first, rd);
    check(rd_count == rc0, "R10 no memory read for buffered block", 64'(rd_count), 64'(rc0));
    check(rd === 32'hCAFE_0001, "R10 data from victim buffer", 64'(rd), 64'hCAFE0001);

    // R11: second dirty eviction stalls until the buffer drains
    access(1, mk(1, 30, 4), 32'h0BAD_0004, 4'hF, first, rd);
    access(1, mk(3, 30, 4), 32'h3333_4444, 4'hF, first, rd);
    rc0 = rd_count;
    stall_done = 1'b0;
    fork
      begin
        access(0, mk(4, 30, 0), 0, 0, first, rd);
        stall_done = 1'b1;
      end
      begin
        repeat (20) @(negedge clk);
        check(rd_count == rc0, "R11 no read while buffer full", 64'(rd_count), 64'(rc0));
        check(stall_done == 1'b0, "R11 request held while buffer full", 64'(stall_done), 64'd0);
        wr_ready_en = 1'b1;
      end
    join
    check(rd === exp_word(mk(4, 30, 0)), "R11 data after stall", 64'(rd), 64'(exp_word(mk(4, 30, 0))));
    repeat (10) @(negedge clk);
    wb = get_line({29'd1, 9'd30});
    check(wb[31:0] === 32'hCAFE_0001, "R9 written block word 0", 64'(wb[31:0]), 64'hCAFE0001);
    check(wb[63:32] === 32'h0BAD_0004, "R9 written block word 1", 64'(wb[63:32]), 64'h0BAD0004);
    access(0, mk(1, 30, 4), 0, 0, first, rd);
    check(rd === 32'h0BAD_0004, "R9 read back from memory", 64'(rd), 64'h0BAD0004);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule